// File: doc/BRIEF.md
# 32-Pin GPIO Port with Interrupt Logic

This block is a 32-pin general-purpose I/O port behind a plain register interface with one write strobe and one address that also selects the read data. Each pin has an output value, an active-low drive enable and a blink enable. Each pin also has an input inversion bit. Pin inputs pass through a two-flop synchronizer. They are then XORed with the inversion bit to form the data-in vector. Software and the interrupt logic both use this vector.

A rising edge of a data-in bit sets a sticky cause bit. Software acknowledges a cause bit by writing 0 to that bit position. A single interrupt line combines two sources: cause bits enabled by the edge mask, and data-in bits enabled by the level mask. The inversion bit feeds both interrupt paths. Software can therefore detect both edges on a pin. It inverts the bit after each event, so the opposite transition of the pin is the next rising edge of data-in.

Blinking replaces a pin's output value with a shared square wave. The wave toggles every `BLINK_HALF` clock cycles.

Top module: `gpio_port_top`

## Requirements
- R1: After reset, data out, blink enable, inversion, cause, edge mask and level mask are all zero, and the drive-enable register is all ones, so every pin is an input. `irq` is 0.
- R2: The data-in value equals the synchronized raw pin value XOR the inversion register. A pin change is seen as data in after two clock edges. An inversion change is seen at once.
- R3: A 0-to-1 transition of a data-in bit sets that pin's cause bit. A pin that rises before clock edge k reads as a set cause bit after edge k+2, and not before that edge. A 1-to-0 transition sets nothing.
- R4: On a write to the cause register, each cause bit is ANDed with the write data. A 0 clears the bit, a 1 keeps it, and writing all zeros clears every cause bit. Cause bits never clear without a write to the cause register.
- R5: If a new rising edge and a write that clears the same cause bit fall in the same cycle, the cause bit ends up set.
- R6: `irq` is 1 exactly when some pin has (cause AND edge mask) or (data in AND level mask). With both masks zero, `irq` is 0 whatever causes are pending.
- R7: `pin_drv_n` presents the drive-enable register. A 0 bit means the pin is driven from `pin_out`, and a 1 bit means the pin is an input.
- R8: A pin whose blink bit is 0 outputs its data-out bit. A pin whose blink bit is 1 outputs a shared phase that toggles every `BLINK_HALF` cycles.
- R9: Both-edge detection works as follows. With inversion set to 1 after a rising event, a falling pin sets the cause bit. The inversion write itself sets no cause bit.
- R10: The data-in address is read only. A write to it changes no register.
- R11: The register addresses are: 0 data out, 1 drive enable (active low), 2 blink enable, 3 inversion, 4 data in, 5 cause, 6 edge mask, 7 level mask. Bit i of each register belongs to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 3 | Register address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| pin_in | input | 32 | Raw pin inputs, asynchronous |
| pin_out | output | 32 | Output value per pin |
| pin_drv_n | output | 32 | Active-low drive enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that:
- cause bits stay sticky unless the cause register is written;
- a detected rising edge always leaves its cause bit set, even when a clear arrives in the same cycle;
- an enabled level input forces `irq`, and zero masks keep `irq` low;
- the blink phase toggles only at the end of its count.

The directed scenarios are needed to show the rest:
- the exact synchronizer latency;
- the inversion XOR;
- the partial acknowledge pattern;
- the both-edge sequence driven by inversion writes;
- that writes to data in have no effect;
- the measured blink period.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned PIN_W  = 32;
    localparam int unsigned ADDR_W = 3;

    typedef logic [PIN_W-1:0] pinvec_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_DOUT  = 3'd0,
        RA_DRV_N = 3'd1,
        RA_BLINK = 3'd2,
        RA_INV   = 3'd3,
        RA_DIN   = 3'd4,
        RA_CAUSE = 3'd5,
        RA_EMASK = 3'd6,
        RA_LMASK = 3'd7
    } reg_addr_e;

    typedef struct packed {
        pinvec_t dout;
        pinvec_t drv_n;
        pinvec_t blink;
        pinvec_t inv;
        pinvec_t emask;
        pinvec_t lmask;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{dout: '0, drv_n: '1, blink: '0,
                                   inv: '0, emask: '0, lmask: '0};

    // Acknowledge by AND with write data; fresh edges override the clear.
    function automatic pinvec_t cause_next(pinvec_t cur, logic we,
                                           pinvec_t wd, pinvec_t rise);
        pinvec_t kept;
        kept = we ? (cur & wd) : cur;
        return kept | rise;
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_blink.sv
module gpio_port_blink #(
    parameter int unsigned HALF = 16
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LIM = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == LIM) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    AST_BLINK_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> ($past(cnt) == LIM)); // R8
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_port_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t din,
    input  pinvec_t emask,
    input  pinvec_t lmask,
    input  logic    clr_we,
    input  pinvec_t clr_wd,
    output pinvec_t cause,
    output logic    irq
);
    pinvec_t prev_din;
    pinvec_t rise;

    assign rise = din & ~prev_din;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_din <= '0;
            cause    <= '0;
        end else begin
            prev_din <= din;
            cause    <= cause_next(cause, clr_we, clr_wd, rise);
        end
    end

    assign irq = |((cause & emask) | (din & lmask));

    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(clr_we) |-> ((cause & $past(cause)) == $past(cause))); // R4
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
        ($past(rise) != '0) |-> ((cause & $past(rise)) == $past(rise))); // R5
    AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (rst)
        ((din & lmask) != '0) |-> irq); // R6
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((emask == '0) && (lmask == '0)) |-> !irq); // R6
endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top
    import gpio_port_pkg::*;
#(
    parameter int unsigned BLINK_HALF  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_drv_n,
    output logic              irq
);
    cfg_t    cfg;
    pinvec_t raw_sync;
    pinvec_t din;
    pinvec_t cause;
    logic    blink_phase;
    logic    clr_we;

    gpio_port_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(raw_sync));

    assign din = raw_sync ^ cfg.inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                RA_DOUT:  cfg.dout  <= bus_wdata;
                RA_DRV_N: cfg.drv_n <= bus_wdata;
                RA_BLINK: cfg.blink <= bus_wdata;
                RA_INV:   cfg.inv   <= bus_wdata;
                RA_EMASK: cfg.emask <= bus_wdata;
                RA_LMASK: cfg.lmask <= bus_wdata;
                default:  ;
            endcase
        end
    end

    assign clr_we = bus_wr && (reg_addr_e'(bus_addr) == RA_CAUSE);

    gpio_port_irq u_irq (
        .clk(clk), .rst(rst), .din(din), .emask(cfg.emask), .lmask(cfg.lmask),
        .clr_we(clr_we), .clr_wd(bus_wdata), .cause(cause), .irq(irq));

    gpio_port_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk(clk), .rst(rst), .phase(blink_phase));

    assign pin_out   = (cfg.dout & ~cfg.blink) | ({PIN_W{blink_phase}} & cfg.blink);
    assign pin_drv_n = cfg.drv_n;

    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_DOUT:  bus_rdata = cfg.dout;
            RA_DRV_N: bus_rdata = cfg.drv_n;
            RA_BLINK: bus_rdata = cfg.blink;
            RA_INV:   bus_rdata = cfg.inv;
            RA_DIN:   bus_rdata = din;
            RA_CAUSE: bus_rdata = cause;
            RA_EMASK: bus_rdata = cfg.emask;
            default:  bus_rdata = cfg.lmask;
        endcase
    end

    AST_DRV_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && (bus_addr == RA_DRV_N)) |-> (pin_drv_n == $past(bus_wdata))); // R7
endmodule

// File: tb/gpio_port_top_tb_top.sv
module gpio_port_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_drv_n;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_top #(.BLINK_HALF(HALF)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_drv_n(pin_drv_n), .irq(irq));

    localparam logic [2:0] A_DOUT = 3'd0, A_DRV = 3'd1, A_BLINK = 3'd2, A_INV = 3'd3,
                           A_DIN = 3'd4, A_CAUSE = 3'd5, A_EM = 3'd6, A_LM = 3'd7;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cleanup();
        pin_in = '0;
        idle(4);
        wr(A_INV, '0); wr(A_EM, '0); wr(A_LM, '0); wr(A_BLINK, '0);
        idle(3);
        wr(A_CAUSE, '0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        rd(A_DOUT, v);  chk("R1 dout", v, 32'h0);
        rd(A_DRV, v);   chk("R1 drv_n", v, 32'hFFFF_FFFF);
        rd(A_BLINK, v); chk("R1 blink", v, 32'h0);
        rd(A_INV, v);   chk("R1 inv", v, 32'h0);
        rd(A_CAUSE, v); chk("R1 cause", v, 32'h0);
        rd(A_EM, v);    chk("R11 emask addr", v, 32'h0);
        rd(A_LM, v);    chk("R11 lmask addr", v, 32'h0);
        chk("R1 pin_drv_n", pin_drv_n, 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_polarity();
        logic [31:0] v;
        pin_in = 32'h0000_00F0;
        idle(3);
        rd(A_DIN, v); chk("R2 din raw", v, 32'h0000_00F0);
        wr(A_INV, 32'h0000_0FF0);
        rd(A_DIN, v); chk("R2 din inverted", v, 32'h0000_0F00);
        wr(A_DIN, 32'hFFFF_FFFF);
        rd(A_DIN, v); chk("R10 din write ignored", v, 32'h0000_0F00);
        rd(A_DOUT, v); chk("R10 dout untouched", v, 32'h0);
        rd(A_INV, v); chk("R11 inv readback", v, 32'h0000_0FF0);
        cleanup();
    endtask

    task automatic t_edge();
        logic [31:0] v;
        @(negedge clk);
        pin_in[2] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(A_CAUSE, v); chk("R3 cause not yet", v, 32'h0);
        @(negedge clk);
        rd(A_CAUSE, v); chk("R3 cause set at k+2", v, 32'h0000_0004);
        wr(A_CAUSE, '0);
        pin_in[2] = 1'b0;
        idle(4);
        rd(A_CAUSE, v); chk("R3 fall sets nothing", v, 32'h0);
        cleanup();
    endtask

    task automatic t_ack();
        logic [31:0] v;
        pin_in = 32'h0000_0212;
        idle(4);
        rd(A_CAUSE, v); chk("R4 three causes", v, 32'h0000_0212);
        wr(A_CAUSE, ~32'h0000_0010);
        rd(A_CAUSE, v); chk("R4 partial ack", v, 32'h0000_0202);
        wr(A_CAUSE, 32'hFFFF_FFFF);
        rd(A_CAUSE, v); chk("R4 ones keep", v, 32'h0000_0202);
        wr(A_CAUSE, 32'h0);
        rd(A_CAUSE, v); chk("R4 zero clears all", v, 32'h0);
        cleanup();
    endtask

    task automatic t_race();
        logic [31:0] v;
        pin_in[11] = 1'b1;
        idle(4);
        @(negedge clk);
        pin_in[10] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_CAUSE; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(A_CAUSE, v); chk("R5 edge beats clear", v, 32'h0000_0400);
        cleanup();
    endtask

    task automatic t_irq();
        pin_in[6] = 1'b1;
        idle(4);
        chk("R6 masked cause no irq", {31'd0, irq}, 32'h0);
        wr(A_EM, 32'h0000_0040);
        chk("R6 edge irq", {31'd0, irq}, 32'h1);
        wr(A_EM, 32'h0);
        chk("R6 edge masked off", {31'd0, irq}, 32'h0);
        wr(A_LM, 32'h0000_0100);
        chk("R6 level low no irq", {31'd0, irq}, 32'h0);
        pin_in[8] = 1'b1;
        idle(3);
        chk("R6 level irq", {31'd0, irq}, 32'h1);
        pin_in[8] = 1'b0;
        idle(3);
        chk("R6 level released", {31'd0, irq}, 32'h0);
        cleanup();
    endtask

    task automatic t_drive();
        wr(A_DRV, 32'hFFFF_0000);
        chk("R7 drv_n pins", pin_drv_n, 32'hFFFF_0000);
        wr(A_DRV, 32'hFFFF_FFFF);
        chk("R7 all inputs", pin_drv_n, 32'hFFFF_FFFF);
    endtask

    task automatic t_blink();
        int last, ntr, badgap;
        logic prev;
        wr(A_DOUT, 32'h0000_0005);
        chk("R8 static out", pin_out, 32'h0000_0005);
        wr(A_BLINK, 32'h0000_0004);
        last = -1; ntr = 0; badgap = 0;
        prev = pin_out[2];
        for (int c = 0; c < 4*HALF; c++) begin
            @(negedge clk);
            if (pin_out[2] !== prev) begin
                if (last >= 0 && (c - last) != HALF) badgap++;
                last = c; ntr++;
            end
            prev = pin_out[2];
            if (pin_out[0] !== 1'b1) badgap++;
        end
        chk("R8 toggle count", ntr, 4);
        chk("R8 toggle spacing", badgap, 0);
        wr(A_BLINK, 32'h0);
        chk("R8 blink off", pin_out, 32'h0000_0005);
        wr(A_DOUT, 32'h0);
    endtask

    task automatic t_both();
        logic [31:0] v;
        pin_in[5] = 1'b1;
        idle(4);
        rd(A_CAUSE, v); chk("R9 rise event", v, 32'h0000_0020);
        wr(A_INV, 32'h0000_0020);
        wr(A_CAUSE, 32'h0);
        idle(2);
        rd(A_CAUSE, v); chk("R9 inversion write quiet", v, 32'h0);
        pin_in[5] = 1'b0;
        idle(4);
        rd(A_CAUSE, v); chk("R9 fall event", v, 32'h0000_0020);
        cleanup();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        t_reset();
        t_polarity();
        t_edge();
        t_ack();
        t_race();
        t_irq();
        t_drive();
        t_blink();
        t_both();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule